// File: doc/BRIEF.md
# SMBus Host Controller Register Front-End

This block holds the byte-wide register set of an SMBus host controller and turns a software "start" into a sequence of byte requests for a separate bus engine. Software loads the target address, the command byte and the data registers, then writes the control register with the start bit set. The block picks the protocol from the control register, works out the read or write direction from the address register, and issues address, write, read and stop requests one at a time. Read results go back into the data registers or the block buffer, and the outcome is reported in the status register.

The engine is abstract. It sees one request at a time (`eng_req`, `eng_op`, `eng_wdata`) and answers with a one-cycle `eng_ack`, with `eng_nack` for a refused byte and `eng_rdata` for a read byte. Op codes: 0 = address (start or repeated start), 1 = write byte, 2 = read byte, 3 = stop. A 32-entry block buffer is reached through a single data port whose index advances on every access.

The sequencer has these states: IDLE, ADDR (first address byte), CMD (command byte), ADDR_RD (repeated-start address with the read bit), WR_LO, WR_HI, WR_BLK, RD_LO, RD_HI, RD_BLK and STOP. Each non-idle state holds one request until it is acknowledged. IDLE goes to ADDR on a start with a supported protocol. ADDR goes to STOP for quick, to RD_LO for a byte read, and otherwise to CMD. CMD goes to STOP for a byte write, to ADDR_RD for reads, and otherwise to WR_LO. ADDR_RD goes to RD_LO. WR_LO goes to WR_HI for word and to WR_BLK for a block with a nonzero count, and otherwise to STOP. RD_LO follows the same pattern into RD_HI or RD_BLK. WR_HI and RD_HI go to STOP. WR_BLK and RD_BLK repeat until the count is reached and then go to STOP. A NACK from any state except STOP goes to STOP. STOP goes to IDLE.

Top module: `smb_host_regs`

## Requirements
- R1: After reset, all registers, the block buffer and the buffer index are zero, status reads 0 and no engine request is made.
- R2: The register offsets are: 0 status (bit 0 busy, bit 1 done, bit 2 error), 2 control, 3 command, 4 address, 5 data-low, 6 data-high and 7 block port. A control read returns only the stored bits 4:0 and also returns the block index to 0.
- R3: Each read or write at offset 7 accesses the buffer entry at the index and then increments the index. The index goes from 31 back to 0.
- R4: A control write with bit 6 set while idle starts a transaction. The protocol comes from control bits 4:2 (0 quick, 1 byte, 2 byte data, 3 word, 5 block), and address bit 0 gives the direction (1 read). Starting clears done and error, and busy reads 1 until the final stop is acknowledged. A clean finish then sets done.
- R5: The request sequences are:
  - quick: ADDR(address), then STOP.
  - byte read: ADDR(address), RD, then STOP.
  - byte write: ADDR(address), WR(command), then STOP.
  - byte data: ADDR(address with bit 0 cleared), WR(command), then either WR(data-low) or ADDR(address), RD; then STOP.
  - word: the same as byte data, with two data bytes.
  - block: ADDR(address with bit 0 cleared), WR(command), then either WR(count) and the data bytes, or ADDR(address), RD(count) and RD for each byte; then STOP.
- R6: On reads, the first data byte goes to data-low and the second to data-high. On a block read, the count byte goes to data-low and the bytes go to the buffer from entry 0 upward. Writes leave data-low and data-high unchanged.
- R7: A block write takes its count from data-low and its bytes from buffer entries 0 upward. A count of 0 on a block read or write sends no data bytes.
- R8: A request keeps its op code and byte unchanged until the engine acknowledges it.
- R9: A NACK stops further data requests. The block issues STOP and then sets error instead of done, and a byte that was refused on read is not stored.
- R10: Protocol codes 4, 6 and 7 set error at once and make no engine request.
- R11: Writing 1 to status bit 1 or bit 2 clears that bit alone. Writing 0 leaves it set. Busy cannot be written.
- R12: While busy, writes to control, command, address, data-low, data-high and the block port are ignored. This includes a second start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read side effects) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| eng_req | output | 1 | Engine request valid |
| eng_op | output | 2 | Engine op: 0 address, 1 write, 2 read, 3 stop |
| eng_wdata | output | 8 | Byte for address and write ops, 0 otherwise |
| eng_ack | input | 1 | One-cycle request acknowledge |
| eng_nack | input | 1 | Byte refused, valid with eng_ack |
| eng_rdata | input | 8 | Read byte, valid with eng_ack |

## Verification
The assertions check the engine handshake on every cycle: a pending request keeps its op and byte, and every transaction ends with an acknowledged stop. They also check that busy never falls without done or error being set, and that done and error are never set together. The bench scenarios cover the rest. These are the exact request order for each protocol and direction, the placement of read data in the registers and the buffer, block counts of zero, index wrap, write-one-to-clear, rejection of unsupported codes, NACK handling, and writes that are ignored while busy.

// File: rtl/smb_pkg.sv
package smb_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_ADDR = 2'd0,
        OP_WR   = 2'd1,
        OP_RD   = 2'd2,
        OP_STOP = 2'd3
    } eng_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_CMD, S_ADDR_RD,
        S_WR_LO, S_WR_HI, S_WR_BLK,
        S_RD_LO, S_RD_HI, S_RD_BLK, S_STOP
    } seq_state_e;

    localparam logic [2:0] PROT_QUICK = 3'd0;
    localparam logic [2:0] PROT_BYTE  = 3'd1;
    localparam logic [2:0] PROT_BDATA = 3'd2;
    localparam logic [2:0] PROT_WORD  = 3'd3;
    localparam logic [2:0] PROT_BLOCK = 3'd5;

    localparam logic [2:0] OFF_STS = 3'd0;
    localparam logic [2:0] OFF_CTL = 3'd2;
    localparam logic [2:0] OFF_CMD = 3'd3;
    localparam logic [2:0] OFF_ADR = 3'd4;
    localparam logic [2:0] OFF_LO  = 3'd5;
    localparam logic [2:0] OFF_HI  = 3'd6;
    localparam logic [2:0] OFF_BLK = 3'd7;
endpackage

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ridx_a,
    output logic [W-1:0]  rdata_a,
    input  logic [IW-1:0] ridx_b,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++)
                if (we && widx == IW'(i)) mem[i] <= wdata;
        end
    end

    assign rdata_a = mem[ridx_a];
    assign rdata_b = mem[ridx_b];
endmodule

// File: rtl/smb_seq.sv
module smb_seq
    import smb_pkg::*;
#(
    parameter int IW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        prot,
    input  logic              rd,
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic [BYTE_W-1:0] cmd,
    input  logic [BYTE_W-1:0] lo,
    input  logic [BYTE_W-1:0] hi,
    input  logic [BYTE_W-1:0] blk_rdata,
    input  logic              eng_ack,
    input  logic              eng_nack,
    input  logic [BYTE_W-1:0] eng_rdata,
    output logic              eng_req,
    output logic [1:0]        eng_op,
    output logic [BYTE_W-1:0] eng_wdata,
    output logic              busy,
    output logic              cap_lo,
    output logic              cap_hi,
    output logic              cap_blk,
    output logic [IW-1:0]     blk_idx,
    output logic              fin_ok,
    output logic              fin_err
);
    seq_state_e        state_q, state_d;
    logic [BYTE_W-1:0] ptr_q, ptr_inc;
    logic              nacked_q;
    logic              supported, good_ack;
    eng_op_e           op_c;

    assign supported = (prot == PROT_QUICK) || (prot == PROT_BYTE) ||
                       (prot == PROT_BDATA) || (prot == PROT_WORD) ||
                       (prot == PROT_BLOCK);
    assign good_ack  = eng_ack && !eng_nack;
    assign ptr_inc   = ptr_q + 8'd1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            nacked_q <= 1'b0;
        end else if (start) begin
            ptr_q    <= '0;
            nacked_q <= 1'b0;
        end else begin
            if (good_ack && (state_q == S_WR_BLK || state_q == S_RD_BLK))
                ptr_q <= ptr_inc;
            if (eng_ack && eng_nack && state_q != S_STOP)
                nacked_q <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start && supported) state_d = S_ADDR;
            S_ADDR:    if (good_ack) begin
                           if (prot == PROT_QUICK)          state_d = S_STOP;
                           else if (prot == PROT_BYTE && rd) state_d = S_RD_LO;
                           else                              state_d = S_CMD;
                       end
            S_CMD:     if (good_ack) begin
                           if (prot == PROT_BYTE) state_d = S_STOP;
                           else if (rd)           state_d = S_ADDR_RD;
                           else                   state_d = S_WR_LO;
                       end
            S_ADDR_RD: if (good_ack) state_d = S_RD_LO;
            S_WR_LO:   if (good_ack) begin
                           if (prot == PROT_WORD)                    state_d = S_WR_HI;
                           else if (prot == PROT_BLOCK && lo != '0)  state_d = S_WR_BLK;
                           else                                      state_d = S_STOP;
                       end
            S_WR_HI:   if (good_ack) state_d = S_STOP;
            S_WR_BLK:  if (good_ack && ptr_inc == lo) state_d = S_STOP;
            S_RD_LO:   if (good_ack) begin
                           if (prot == PROT_WORD)                          state_d = S_RD_HI;
                           else if (prot == PROT_BLOCK && eng_rdata != '0) state_d = S_RD_BLK;
                           else                                            state_d = S_STOP;
                       end
            S_RD_HI:   if (good_ack) state_d = S_STOP;
            S_RD_BLK:  if (good_ack && ptr_inc == lo) state_d = S_STOP;
            S_STOP:    if (eng_ack) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
        if (state_q != S_IDLE && state_q != S_STOP && eng_ack && eng_nack)
            state_d = S_STOP;
    end

    always_comb begin
        op_c      = OP_STOP;
        eng_wdata = '0;
        unique case (state_q)
            S_IDLE:    op_c = OP_STOP;
            S_ADDR:    begin
                           op_c      = OP_ADDR;
                           eng_wdata = (prot == PROT_QUICK || prot == PROT_BYTE) ?
                                       addr_byte : {addr_byte[BYTE_W-1:1], 1'b0};
                       end
            S_CMD:     begin op_c = OP_WR;   eng_wdata = cmd;       end
            S_ADDR_RD: begin op_c = OP_ADDR; eng_wdata = addr_byte; end
            S_WR_LO:   begin op_c = OP_WR;   eng_wdata = lo;        end
            S_WR_HI:   begin op_c = OP_WR;   eng_wdata = hi;        end
            S_WR_BLK:  begin op_c = OP_WR;   eng_wdata = blk_rdata; end
            S_RD_LO, S_RD_HI, S_RD_BLK: op_c = OP_RD;
            S_STOP:    op_c = OP_STOP;
            default:   op_c = OP_STOP;
        endcase
        eng_req = (state_q != S_IDLE);
        busy    = (state_q != S_IDLE);
        cap_lo  = good_ack && state_q == S_RD_LO;
        cap_hi  = good_ack && state_q == S_RD_HI;
        cap_blk = good_ack && state_q == S_RD_BLK;
        fin_ok  = state_q == S_STOP && eng_ack && !nacked_q;
        fin_err = (state_q == S_STOP && eng_ack && nacked_q) ||
                  (state_q == S_IDLE && start && !supported);
    end

    assign eng_op  = op_c;
    assign blk_idx = ptr_q[IW-1:0];
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        eng_req,
    output logic [1:0]  eng_op,
    output logic [7:0]  eng_wdata,
    input  logic        eng_ack,
    input  logic        eng_nack,
    input  logic [7:0]  eng_rdata
);
    localparam int IW = $clog2(DEPTH);

    logic [4:0]        ctl_q;
    logic [BYTE_W-1:0] cmd_q, adr_q, lo_q, hi_q;
    logic              done_q, err_q;
    logic [IW-1:0]     hidx_q;
    logic              seq_busy, wr_ok, start;
    logic              cap_lo, cap_hi, cap_blk, fin_ok, fin_err;
    logic [IW-1:0]     blk_idx, buf_widx;
    logic [BYTE_W-1:0] host_rbyte, eng_rbyte, buf_wdata;
    logic              buf_we;
    logic [2:0]        prot_sel;

    assign wr_ok    = reg_wr && !seq_busy;
    assign start    = wr_ok && reg_addr == OFF_CTL && reg_wdata[6];
    assign prot_sel = start ? reg_wdata[4:2] : ctl_q[4:2];

    assign buf_we    = seq_busy ? cap_blk : (wr_ok && reg_addr == OFF_BLK);
    assign buf_widx  = seq_busy ? blk_idx : hidx_q;
    assign buf_wdata = seq_busy ? eng_rdata : reg_wdata;

    smb_blk_buf #(.DEPTH(DEPTH), .W(BYTE_W), .IW(IW)) u_buf (
        .clk(clk), .rst_n(rst_n), .we(buf_we), .widx(buf_widx), .wdata(buf_wdata),
        .ridx_a(hidx_q), .rdata_a(host_rbyte), .ridx_b(blk_idx), .rdata_b(eng_rbyte)
    );

    smb_seq #(.IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .prot(prot_sel), .rd(adr_q[0]),
        .addr_byte(adr_q), .cmd(cmd_q), .lo(lo_q), .hi(hi_q), .blk_rdata(eng_rbyte),
        .eng_ack(eng_ack), .eng_nack(eng_nack), .eng_rdata(eng_rdata),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata), .busy(seq_busy),
        .cap_lo(cap_lo), .cap_hi(cap_hi), .cap_blk(cap_blk), .blk_idx(blk_idx),
        .fin_ok(fin_ok), .fin_err(fin_err)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            cmd_q  <= '0;
            adr_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            hidx_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (wr_ok) begin
                unique case (reg_addr)
                    OFF_CTL: ctl_q  <= reg_wdata[4:0];
                    OFF_CMD: cmd_q  <= reg_wdata;
                    OFF_ADR: adr_q  <= reg_wdata;
                    OFF_LO:  lo_q   <= reg_wdata;
                    OFF_HI:  hi_q   <= reg_wdata;
                    OFF_BLK: hidx_q <= hidx_q + IW'(1);
                    default: ;
                endcase
            end
            if (reg_rd && reg_addr == OFF_BLK) hidx_q <= hidx_q + IW'(1);
            if (reg_rd && reg_addr == OFF_CTL) hidx_q <= '0;
            if (cap_lo) lo_q <= eng_rdata;
            if (cap_hi) hi_q <= eng_rdata;
            if (reg_wr && reg_addr == OFF_STS) begin
                if (reg_wdata[1]) done_q <= 1'b0;
                if (reg_wdata[2]) err_q  <= 1'b0;
            end
            if (start) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end
            if (fin_ok)  done_q <= 1'b1;
            if (fin_err) err_q  <= 1'b1;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFF_STS: reg_rdata = {5'b0, err_q, done_q, seq_busy};
            OFF_CTL: reg_rdata = {3'b0, ctl_q};
            OFF_CMD: reg_rdata = cmd_q;
            OFF_ADR: reg_rdata = adr_q;
            OFF_LO:  reg_rdata = lo_q;
            OFF_HI:  reg_rdata = hi_q;
            OFF_BLK: reg_rdata = host_rbyte;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       eng_req,
    input logic       eng_ack,
    input logic [1:0] eng_op,
    input logic [7:0] eng_wdata,
    input logic       busy,
    input logic       done,
    input logic       err
);
    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=> (eng_req && $stable(eng_op) && $stable(eng_wdata)));

    // R5
    stop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(eng_op) == 2'd3 && $past(eng_ack)));

    // R4
    finish_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || err));

    // R9
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
endmodule

bind smb_host_regs smb_host_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .eng_ack(eng_ack),
    .eng_op(eng_op), .eng_wdata(eng_wdata), .busy(seq_busy),
    .done(done_q), .err(err_q)
);

// File: tb/test_smb_host_regs.sv
`timescale 1ns/100ps
module test_smb_host_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       eng_req, eng_ack = 1'b0, eng_nack = 1'b0;
    logic [1:0] eng_op;
    logic [7:0] eng_wdata, eng_rdata = '0;

    int n_chk = 0, n_fail = 0;
    logic [9:0] log_q [64];
    logic [9:0] exp_q [64];
    logic [7:0] resp [64];
    logic [7:0] wb [64];
    int log_n = 0, exp_n = 0, rd_n = 0, nack_at = -1, dly_max = 0, dly_fix = 0, dly_cnt = 0;
    logic [7:0] x, t_addr, t_cmd, t_lo, t_hi;
    logic [2:0] t_prot;
    int t_cnt;
    bit t_rd, finished = 0;

    always #2 clk = ~clk;

    smb_host_regs i_smb_host_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_req(eng_req), .eng_op(eng_op),
        .eng_wdata(eng_wdata), .eng_ack(eng_ack), .eng_nack(eng_nack), .eng_rdata(eng_rdata)
    );

    // engine model: acknowledges after a delay, logs every request
    always @(negedge clk) begin
        if (eng_ack) begin
            eng_ack  = 1'b0;
            eng_nack = 1'b0;
        end else if (eng_req) begin
            if (dly_cnt > 0) dly_cnt--;
            else begin
                if (log_n < 64) log_q[log_n] = {eng_op, eng_wdata};
                eng_nack = (log_n == nack_at);
                log_n++;
                if (eng_op == 2'd2) begin
                    eng_rdata = resp[rd_n % 64];
                    rd_n++;
                end
                eng_ack = 1'b1;
                dly_cnt = (dly_fix > 0) ? dly_fix : int'($urandom_range(dly_max, 0));
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #0.5 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(3'd0, s);
            if (!s[0]) break;
        end
    endtask

    task automatic push(input logic [1:0] op, input logic [7:0] b);
        exp_q[exp_n] = {op, b};
        exp_n++;
    endtask

    task automatic build_exp(input logic [2:0] p, input bit r, input logic [7:0] a,
                             input logic [7:0] c, input logic [7:0] lo,
                             input logic [7:0] hi, input int cnt);
        exp_n = 0;
        push(2'd0, (p == 3'd0 || p == 3'd1) ? a : {a[7:1], 1'b0});
        case (p)
            3'd1: if (r) push(2'd2, 8'h00); else push(2'd1, c);
            3'd2: begin
                push(2'd1, c);
                if (r) begin push(2'd0, a); push(2'd2, 8'h00); end
                else push(2'd1, lo);
            end
            3'd3: begin
                push(2'd1, c);
                if (r) begin push(2'd0, a); push(2'd2, 8'h00); push(2'd2, 8'h00); end
                else begin push(2'd1, lo); push(2'd1, hi); end
            end
            3'd5: begin
                push(2'd1, c);
                if (r) begin
                    push(2'd0, a); push(2'd2, 8'h00);
                    for (int i = 0; i < cnt; i++) push(2'd2, 8'h00);
                end else begin
                    push(2'd1, lo);
                    for (int i = 0; i < cnt; i++) push(2'd1, wb[i]);
                end
            end
            default: ;
        endcase
        push(2'd3, 8'h00);
    endtask

    task automatic compare_log(input string tag);
        check({tag, " request count"}, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) check({tag, " request"}, log_q[i], exp_q[i]);
    endtask

    task automatic start_txn(input logic [2:0] p, input logic [7:0] a, input logic [7:0] c,
                             input logic [7:0] lo, input logic [7:0] hi);
        log_n = 0; rd_n = 0;
        wr(3'd4, a); wr(3'd3, c); wr(3'd5, lo); wr(3'd6, hi);
        wr(3'd2, {1'b0, 1'b1, 1'b0, p, 2'b00});
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, x); check("R1 status", x, 0);
        rd(3'd2, x); check("R1 control", x, 0);
        rd(3'd5, x); check("R1 data-low", x, 0);
        rd(3'd7, x); check("R1 buffer", x, 0);
        check("R1 no request", log_n, 0);

        // R2 control readback masks bits 7:5
        wr(3'd2, 8'h9F); rd(3'd2, x); check("R2 control mask", x, 8'h1F);
        wr(3'd3, 8'h5A); rd(3'd3, x); check("R2 command", x, 8'h5A);
        wr(3'd2, 8'h00);

        // R3 index wrap
        rd(3'd2, x);
        for (int i = 0; i < 33; i++) wr(3'd7, 8'(i + 1));
        rd(3'd2, x);
        rd(3'd7, x); check("R3 wrapped entry 0", x, 33);
        rd(3'd7, x); check("R3 entry 1", x, 2);

        // R10 unsupported codes
        log_n = 0;
        wr(3'd2, 8'h50); repeat (4) @(negedge clk);
        rd(3'd0, x); check("R10 code 4 error", x, 8'h04);
        check("R10 code 4 no request", log_n, 0);
        wr(3'd0, 8'h04);
        wr(3'd2, 8'h5C); repeat (4) @(negedge clk);
        rd(3'd0, x); check("R10 code 7 error", x, 8'h04);
        check("R10 code 7 no request", log_n, 0);

        // R11 write-one-to-clear per bit
        wr(3'd0, 8'h02); rd(3'd0, x); check("R11 other bit kept", x, 8'h04);
        wr(3'd0, 8'h04); rd(3'd0, x); check("R11 error cleared", x, 8'h00);
        start_txn(3'd0, 8'h20, 8'h00, 8'h00, 8'h00); wait_idle();
        wr(3'd0, 8'h01); rd(3'd0, x); check("R11 busy not writable", x, 8'h02);
        wr(3'd0, 8'h02); rd(3'd0, x); check("R11 done cleared", x, 8'h00);

        // R9 nack on command byte of a byte write
        nack_at = 1;
        start_txn(3'd1, 8'h44, 8'h77, 8'h11, 8'h22); wait_idle();
        exp_n = 0; push(2'd0, 8'h44); push(2'd1, 8'h77); push(2'd3, 8'h00);
        compare_log("R9 nack write");
        rd(3'd0, x); check("R9 error set", x, 8'h04);
        // R9 nack on the data read of a byte-data read
        nack_at = 3; resp[0] = 8'hC3;
        start_txn(3'd2, 8'h45, 8'h10, 8'h66, 8'h00); wait_idle();
        rd(3'd5, x); check("R9 refused byte not stored", x, 8'h66);
        rd(3'd0, x); check("R9 error after read nack", x, 8'h04);
        nack_at = -1; wr(3'd0, 8'h06);

        // R7 block read with count 0
        resp[0] = 8'h00;
        start_txn(3'd5, 8'h31, 8'h09, 8'hAA, 8'h00); wait_idle();
        build_exp(3'd5, 1'b1, 8'h31, 8'h09, 8'h00, 8'h00, 0);
        compare_log("R7 empty block read");
        rd(3'd5, x); check("R7 zero count stored", x, 8'h00);
        wr(3'd0, 8'h06);

        // R12 writes ignored while busy
        dly_fix = 20;
        start_txn(3'd3, 8'h52, 8'hB1, 8'hB2, 8'hB3);
        wr(3'd3, 8'hEE); wr(3'd6, 8'hEE); wr(3'd2, 8'h44);
        wait_idle(); dly_fix = 0;
        build_exp(3'd3, 1'b0, 8'h52, 8'hB1, 8'hB2, 8'hB3, 0);
        compare_log("R12 busy word write");
        rd(3'd3, x); check("R12 command kept", x, 8'hB1);
        rd(3'd6, x); check("R12 data-high kept", x, 8'hB3);
        rd(3'd2, x); check("R12 control kept", x, 8'h0C);
        wr(3'd0, 8'h06);

        // R4 R5 R6 R7 random transactions
        for (int n = 0; n < 40; n++) begin
            case ($urandom_range(4, 0))
                0: t_prot = 3'd0; 1: t_prot = 3'd1; 2: t_prot = 3'd2;
                3: t_prot = 3'd3; default: t_prot = 3'd5;
            endcase
            t_rd   = 1'($urandom);
            t_addr = {7'($urandom), t_rd};
            t_cmd  = 8'($urandom); t_hi = 8'($urandom);
            t_cnt  = $urandom_range(8, 0);
            t_lo   = (t_prot == 3'd5) ? 8'(t_cnt) : 8'($urandom);
            dly_max = $urandom_range(3, 0);
            for (int i = 0; i < 16; i++) begin resp[i] = 8'($urandom); wb[i] = 8'($urandom); end
            if (t_prot == 3'd5 && t_rd) resp[0] = 8'(t_cnt);
            if (t_prot == 3'd5 && !t_rd) begin
                rd(3'd2, x);
                for (int i = 0; i < t_cnt; i++) wr(3'd7, wb[i]);
            end
            build_exp(t_prot, t_rd, t_addr, t_cmd, t_lo, t_hi, t_cnt);
            start_txn(t_prot, t_addr, t_cmd, t_lo, t_hi);
            wait_idle();
            compare_log("R5 sequence");
            rd(3'd0, x); check("R4 done after finish", x, 8'h02);
            if (t_rd && t_prot != 3'd0) begin
                rd(3'd5, x); check("R6 data-low", x, resp[0]);
                if (t_prot == 3'd3) begin rd(3'd6, x); check("R6 data-high", x, resp[1]); end
                if (t_prot == 3'd5) begin
                    rd(3'd2, x);
                    for (int i = 0; i < t_cnt; i++) begin
                        rd(3'd7, x); check("R6 block byte", x, resp[i + 1]);
                    end
                end
            end else begin
                rd(3'd5, x); check("R6 write keeps data-low", x, t_lo);
                rd(3'd6, x); check("R6 write keeps data-high", x, t_hi);
            end
            wr(3'd0, 8'h06);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule